// File: doc/BRIEF.md
# Two-Colour Hardware Cursor Overlay

This block lays a 32x32 two-colour pointer over a stream of display pixels. Software programs it through a small register bank. One register holds the cursor origin. There is one transparency-mask word and one pattern word for each cursor row, and one general-purpose miscellaneous register. Each pixel enters with its screen coordinates and its base colour. One cycle later the block returns the base colour, or one of two overlay colours supplied on input pins.

The cursor covers a window of 32 rows and 32 columns that starts at the programmed origin. A set mask bit makes the pixel opaque, and the matching pattern bit then chooses between the two overlay colours. Pixels outside the window, and pixels at or beyond the visible width or height, pass through untouched. On reset the origin is parked far outside any practical screen, so nothing shows until software moves the cursor.

Top module: `cursor_overlay`

## Requirements
- R1: A write to word offset 0x8FC sets the cursor origin, with X taken from data bits 31:16 and Y from data bits 15:0.
- R2: Row r (0..31) of the cursor takes its mask word from a write to offset 0x900 + 4*r and its pattern word from a write to offset 0x980 + 4*r.
- R3: Within a row, data bit 31 controls the column at screen X equal to the cursor X, and cursor column c is controlled by bit 31-c.
- R4: A clear mask bit leaves the base colour. A set mask bit gives `col_hi` (overlay colour 3) when the pattern bit is 1, and `col_lo` (overlay colour 2) when it is 0.
- R5: The window covers screen rows Y..Y+31 and columns X..X+31, compared as unsigned values that do not wrap. Every pixel outside the window keeps its base colour.
- R6: A pixel with x >= `scr_width` or y >= `scr_height` keeps its base colour even inside the window, so the cursor is clipped at the right and bottom edges.
- R7: After reset both origin coordinates are 0xF000, all mask and pattern words are zero, the miscellaneous register is zero and `out_valid` is 0.
- R8: Offset 0x818 is a read/write miscellaneous register whose read value always has bit 25 set to 1. Every other offset, including position, mask and pattern, reads zero.
- R9: The pixel path has exactly one cycle of latency. `out_valid` is `pix_valid` delayed by one cycle, and `out_x`/`out_y` carry the coordinates of the same pixel.
- R10: A register write affects pixels presented in later cycles. A pixel presented in the same cycle as the write still sees the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| scr_width | input | 16 | Visible screen width in pixels |
| scr_height | input | 16 | Visible screen height in lines |
| col_lo | input | COLOR_W | Overlay colour used where the pattern bit is 0 |
| col_hi | input | COLOR_W | Overlay colour used where the pattern bit is 1 |
| pix_valid | input | 1 | Input pixel qualifier |
| pix_x | input | 16 | Input pixel column |
| pix_y | input | 16 | Input pixel row |
| pix_color | input | COLOR_W | Base colour of the input pixel |
| out_valid | output | 1 | Output pixel qualifier |
| out_x | output | 16 | Output pixel column |
| out_y | output | 16 | Output pixel row |
| out_color | output | COLOR_W | Merged output colour |

## Verification
A stored row word with a wrong bit, or a bit-select that counts columns from the wrong end, appears at `out_color` on the first pixel that crosses the affected column. The bench therefore probes both ends of a row and the first column beyond each end. A wrong origin, or window bounds that are off by one, shows up on the pixel just outside each edge, one cycle after that pixel is presented. A write that lands in the wrong row, or takes effect too early, shows up one cycle later on a pixel placed in the same cycle as the write. A stale reset state shows up as an overlay colour at the old origin right after reset is released.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned COORD_W = 16;

  localparam logic [ADDR_W-1:0] OFS_MISC = 12'h818;
  localparam logic [ADDR_W-1:0] OFS_POS  = 12'h8FC;
  localparam logic [ADDR_W-1:0] OFS_MASK = 12'h900;
  localparam logic [ADDR_W-1:0] OFS_PAT  = 12'h980;

  localparam logic [DATA_W-1:0]  MISC_FORCE = 32'h0200_0000;
  localparam logic [COORD_W-1:0] PARK_POS   = 16'hF000;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2
  } pix_sel_e;
endpackage

// File: rtl/cursor_regbank.sv
module cursor_regbank
  import cursor_ovl_pkg::*;
#(
  parameter int unsigned DIM = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            rdata,
  output logic [COORD_W-1:0]           cur_x,
  output logic [COORD_W-1:0]           cur_y,
  output logic [DIM-1:0][DIM-1:0]      mask_rows,
  output logic [DIM-1:0][DIM-1:0]      pat_rows
);
  localparam int unsigned WADDR_W = ADDR_W - 2;
  localparam logic [WADDR_W-1:0] W_POS  = OFS_POS[ADDR_W-1:2];
  localparam logic [WADDR_W-1:0] W_MISC = OFS_MISC[ADDR_W-1:2];
  localparam logic [WADDR_W-1:0] W_MASK = OFS_MASK[ADDR_W-1:2];
  localparam logic [WADDR_W-1:0] W_PAT  = OFS_PAT[ADDR_W-1:2];

  logic [WADDR_W-1:0] waddr;
  assign waddr = addr[ADDR_W-1:2];

  logic               pos_en, misc_en;
  logic [COORD_W-1:0] x_nxt, y_nxt;
  logic [DATA_W-1:0]  misc_q, misc_nxt;

  always_comb begin
    pos_en   = wr_en && (waddr == W_POS);
    misc_en  = wr_en && (waddr == W_MISC);
    x_nxt    = wdata[31:16];
    y_nxt    = wdata[15:0];
    misc_nxt = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_x <= PARK_POS;
      cur_y <= PARK_POS;
    end else if (pos_en) begin
      cur_x <= x_nxt;
      cur_y <= y_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       misc_q <= '0;
    else if (misc_en) misc_q <= misc_nxt;
  end

  for (genvar r = 0; r < DIM; r++) begin : g_row
    logic mask_en, pat_en;
    logic [DIM-1:0] row_nxt;
    always_comb begin
      mask_en = wr_en && (waddr == W_MASK + WADDR_W'(r));
      pat_en  = wr_en && (waddr == W_PAT + WADDR_W'(r));
      row_nxt = wdata[DATA_W-1 -: DIM];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_rows[r] <= '0;
      else if (mask_en) mask_rows[r] <= row_nxt;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pat_rows[r] <= '0;
      else if (pat_en) pat_rows[r] <= row_nxt;
    end
  end

  always_comb begin
    if (waddr == W_MISC) rdata = misc_q | MISC_FORCE;
    else                 rdata = '0;
  end
endmodule

// File: rtl/cursor_window.sv
module cursor_window
  import cursor_ovl_pkg::*;
#(
  parameter int unsigned DIM = 32
) (
  input  logic [COORD_W-1:0]       pix_x,
  input  logic [COORD_W-1:0]       pix_y,
  input  logic [COORD_W-1:0]       cur_x,
  input  logic [COORD_W-1:0]       cur_y,
  input  logic [COORD_W-1:0]       scr_width,
  input  logic [COORD_W-1:0]       scr_height,
  input  logic [DIM-1:0][DIM-1:0]  mask_rows,
  input  logic [DIM-1:0][DIM-1:0]  pat_rows,
  output pix_sel_e                 sel
);
  localparam int unsigned IDX_W = (DIM > 1) ? $clog2(DIM) : 1;
  localparam int unsigned EXT_W = COORD_W + 1;
  localparam logic [EXT_W-1:0] DIM_EXT = EXT_W'(DIM);
  localparam logic [IDX_W-1:0] LAST    = IDX_W'(DIM - 1);

  logic [EXT_W-1:0] dx, dy;
  logic             in_x, in_y, on_screen;
  logic [IDX_W-1:0] row, col, bit_idx;
  logic [DIM-1:0]   mrow, prow;
  logic             mbit, pbit;

  always_comb begin
    dx        = {1'b0, pix_x} - {1'b0, cur_x};
    dy        = {1'b0, pix_y} - {1'b0, cur_y};
    in_x      = (pix_x >= cur_x) && (dx < DIM_EXT);
    in_y      = (pix_y >= cur_y) && (dy < DIM_EXT);
    on_screen = (pix_x < scr_width) && (pix_y < scr_height);
    row       = dy[IDX_W-1:0];
    col       = dx[IDX_W-1:0];
    bit_idx   = LAST - col;
    mrow      = mask_rows[row];
    prow      = pat_rows[row];
    mbit      = mrow[bit_idx];
    pbit      = prow[bit_idx];
    if (in_x && in_y && on_screen && mbit) sel = pbit ? SEL_HI : SEL_LO;
    else                                   sel = SEL_BASE;
  end
endmodule

// File: rtl/cursor_outstage.sv
module cursor_outstage
  import cursor_ovl_pkg::*;
#(
  parameter int unsigned COLOR_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [COORD_W-1:0]  in_x,
  input  logic [COORD_W-1:0]  in_y,
  input  logic [COLOR_W-1:0]  in_color,
  input  logic [COLOR_W-1:0]  col_lo,
  input  logic [COLOR_W-1:0]  col_hi,
  input  pix_sel_e            sel,
  output logic                out_valid,
  output logic [COORD_W-1:0]  out_x,
  output logic [COORD_W-1:0]  out_y,
  output logic [COLOR_W-1:0]  out_color
);
  logic [COLOR_W-1:0] color_nxt;

  always_comb begin
    unique case (sel)
      SEL_LO:  color_nxt = col_lo;
      SEL_HI:  color_nxt = col_hi;
      default: color_nxt = in_color;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_x     <= '0;
      out_y     <= '0;
      out_color <= '0;
    end else if (in_valid) begin
      out_x     <= in_x;
      out_y     <= in_y;
      out_color <= color_nxt;
    end
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_ovl_pkg::*;
#(
  parameter int unsigned COLOR_W = 24,
  parameter int unsigned DIM     = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [11:0]         reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [15:0]         scr_width,
  input  logic [15:0]         scr_height,
  input  logic [COLOR_W-1:0]  col_lo,
  input  logic [COLOR_W-1:0]  col_hi,
  input  logic                pix_valid,
  input  logic [15:0]         pix_x,
  input  logic [15:0]         pix_y,
  input  logic [COLOR_W-1:0]  pix_color,
  output logic                out_valid,
  output logic [15:0]         out_x,
  output logic [15:0]         out_y,
  output logic [COLOR_W-1:0]  out_color
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [COORD_W-1:0]       cur_x, cur_y;
  logic [DIM-1:0][DIM-1:0]  mask_rows, pat_rows;
  pix_sel_e                 sel;

  cursor_regbank #(.DIM(DIM)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .cur_x     (cur_x),
    .cur_y     (cur_y),
    .mask_rows (mask_rows),
    .pat_rows  (pat_rows)
  );

  cursor_window #(.DIM(DIM)) u_win (
    .pix_x      (pix_x),
    .pix_y      (pix_y),
    .cur_x      (cur_x),
    .cur_y      (cur_y),
    .scr_width  (scr_width),
    .scr_height (scr_height),
    .mask_rows  (mask_rows),
    .pat_rows   (pat_rows),
    .sel        (sel)
  );

  cursor_outstage #(.COLOR_W(COLOR_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (pix_valid),
    .in_x      (pix_x),
    .in_y      (pix_y),
    .in_color  (pix_color),
    .col_lo    (col_lo),
    .col_hi    (col_hi),
    .sel       (sel),
    .out_valid (out_valid),
    .out_x     (out_x),
    .out_y     (out_y),
    .out_color (out_color)
  );
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
  parameter int unsigned COLOR_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic [11:0]         reg_addr,
  input logic [31:0]         reg_rdata,
  input logic [15:0]         scr_width,
  input logic [15:0]         scr_height,
  input logic [COLOR_W-1:0]  col_lo,
  input logic [COLOR_W-1:0]  col_hi,
  input logic                pix_valid,
  input logic [15:0]         pix_x,
  input logic [15:0]         pix_y,
  input logic [COLOR_W-1:0]  pix_color,
  input logic                out_valid,
  input logic [15:0]         out_x,
  input logic [15:0]         out_y,
  input logic [COLOR_W-1:0]  out_color
);
  // R9
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);
  // R9
  vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);
  // R9
  coord_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> (out_x == $past(pix_x) && out_y == $past(pix_y)));
  // R6
  offscreen_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && (pix_x >= scr_width || pix_y >= scr_height))
      |=> out_color == $past(pix_color));
  // R4
  colour_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> (out_color == $past(pix_color) || out_color == $past(col_lo)
                   || out_color == $past(col_hi)));
  // R8
  misc_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 12'h818) |-> reg_rdata[25]);
  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[11:2] != 10'h206) |-> (reg_rdata == 32'h0));
endmodule

bind cursor_overlay cursor_overlay_chk #(.COLOR_W(COLOR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .scr_width  (scr_width),
  .scr_height (scr_height),
  .col_lo     (col_lo),
  .col_hi     (col_hi),
  .pix_valid  (pix_valid),
  .pix_x      (pix_x),
  .pix_y      (pix_y),
  .pix_color  (pix_color),
  .out_valid  (out_valid),
  .out_x      (out_x),
  .out_y      (out_y),
  .out_color  (out_color)
);

// File: tb/sim_cursor_overlay.sv
module sim_cursor_overlay;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 24;
  localparam logic [CW-1:0] C_LO = 24'h00AA00;
  localparam logic [CW-1:0] C_HI = 24'h0000BB;

  // expected code: 0 base, 1 col_lo, 2 col_hi
  localparam int NV = 10;
  localparam int VX [NV] = '{100, 101, 102, 131, 132,  99, 100, 100, 100, 115};
  localparam int VY [NV] = '{ 50,  50,  50,  50,  50,  50,  49,  81,  82,  81};
  localparam int VE [NV] = '{  2,   1,   0,   1,   0,   0,   0,   1,   0,   1};

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reg_wr = 1'b0;
  logic [11:0]    reg_addr = '0;
  logic [31:0]    reg_wdata = '0;
  logic [31:0]    reg_rdata;
  logic [15:0]    scr_width = 16'd640;
  logic [15:0]    scr_height = 16'd480;
  logic           pix_valid = 1'b0;
  logic [15:0]    pix_x = '0;
  logic [15:0]    pix_y = '0;
  logic [CW-1:0]  pix_color = '0;
  logic           out_valid;
  logic [15:0]    out_x, out_y;
  logic [CW-1:0]  out_color;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cursor_overlay #(.COLOR_W(CW), .DIM(32)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scr_width(scr_width),
    .scr_height(scr_height), .col_lo(C_LO), .col_hi(C_HI),
    .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y), .pix_color(pix_color),
    .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_color(out_color)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = '0;
  endtask

  function automatic logic [CW-1:0] pick(input int code, input logic [CW-1:0] base);
    return (code == 2) ? C_HI : (code == 1) ? C_LO : base;
  endfunction

  // present one pixel, check result one cycle later, then check valid drop
  task automatic pixel(input string req, input int x, input int y,
                       input logic [CW-1:0] base, input int code);
    @(negedge clk);
    pix_valid = 1'b1; pix_x = 16'(x); pix_y = 16'(y); pix_color = base;
    @(posedge clk); #1;
    check(req, 32'(out_color), 32'(pick(code, base)));
    check("R9 valid", 32'(out_valid), 32'd1);
    check("R9 coords", {out_x, out_y}, {16'(x), 16'(y)});
    @(negedge clk);
    pix_valid = 1'b0;
    @(posedge clk); #1;
    check("R9 valid drop", 32'(out_valid), 32'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R7 reset state
    check("R7 out_valid", 32'(out_valid), 32'd0);
    reg_addr = 12'h818; #1;
    check("R7/R8 misc reset read", reg_rdata, 32'h0200_0000);
    pixel("R7 parked origin, pixel at 0xF000", 16'hF000, 16'hF000, 24'h123456, 0);

    // R1 R2 program origin and rows
    wr(12'h8FC, {16'd100, 16'd50});
    wr(12'h900, 32'hC000_0001);
    wr(12'h980, 32'h8000_0000);
    wr(12'h900 + 12'd124, 32'hFFFF_FFFF);
    wr(12'h980 + 12'd124, 32'h0000_0000);

    // R3 R4 R5 vector walk
    for (int i = 0; i < NV; i++)
      pixel("R3/R4/R5 vector", VX[i], VY[i], 24'h100000 + 24'(i), VE[i]);

    // R8 register reads
    wr(12'h818, 32'hA5A5_A5A5);
    @(negedge clk); reg_addr = 12'h818; #1;
    check("R8 misc forced bit", reg_rdata, 32'hA7A5_A5A5);
    reg_addr = 12'h8FC; #1;
    check("R8 position reads zero", reg_rdata, 32'h0);
    reg_addr = 12'h900; #1;
    check("R8 mask reads zero", reg_rdata, 32'h0);

    // R6 right-edge clip
    wr(12'h8FC, {16'd630, 16'd50});
    wr(12'h900, 32'hFFFF_FFFF);
    wr(12'h980, 32'h0000_0000);
    pixel("R6 last visible column", 639, 50, 24'h0F0F0F, 1);
    pixel("R6 past right edge", 640, 50, 24'h0F0F0F, 0);

    // R6 bottom-edge clip, row 10 all opaque
    wr(12'h8FC, {16'd630, 16'd470});
    wr(12'h900 + 12'd40, 32'hFFFF_FFFF);
    wr(12'h980 + 12'd40, 32'hFFFF_FFFF);
    scr_height = 16'd481;
    pixel("R6 row on screen", 632, 480, 24'h333333, 2);
    scr_height = 16'd480;
    pixel("R6 row beyond height", 632, 480, 24'h333333, 0);

    // R10 write and pixel in the same cycle
    wr(12'h8FC, {16'd100, 16'd50});
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 12'h8FC; reg_wdata = {16'd200, 16'd50};
    pix_valid = 1'b1; pix_x = 16'd100; pix_y = 16'd50; pix_color = 24'h445566;
    @(posedge clk); #1;
    check("R10 same-cycle pixel sees old origin", 32'(out_color), 32'(C_LO));
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = '0; pix_valid = 1'b0;
    pixel("R10 next pixel sees new origin (old spot)", 100, 50, 24'h445566, 0);
    pixel("R10 next pixel sees new origin (new spot)", 200, 50, 24'h445566, 1);

    // R5 no wraparound near coordinate top
    wr(12'h8FC, {16'hFFF0, 16'd50});
    pixel("R5 no wrap to column 0", 0, 50, 24'h777777, 0);

    // R7 reset mid-run parks cursor and clears rows
    do_reset();
    pixel("R7 parked after reset", 100, 50, 24'h888888, 0);
    wr(12'h8FC, {16'd100, 16'd50});
    pixel("R7 mask cleared by reset", 100, 50, 24'h888888, 0);
    @(negedge clk); reg_addr = 12'h818; #1;
    check("R7 misc cleared by reset", reg_rdata, 32'h0200_0000);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule